// File: doc/BRIEF.md
# Qualified Data Trace Message Generator

This block watches every access that a processor places on its data bus (address, data, direction and a valid strobe) and turns the accesses of interest into compact trace messages for a debug port. Software programs three registers: the lowest and highest traced address, and a control word. The control word holds an enable bit and a mask that selects reads, writes or both. An access produces a message only when it passes the address test and the direction test.

Messages go into a small first-in first-out queue. The consumer drains the queue with a valid/ready handshake. The block saves bandwidth on addresses. After a reference is set, each message carries only the XOR of the previous reported address and the current one, cut to the nibbles up to the highest one that changed. A receiver rebuilds the real address by XORing this payload into its copy of the reference. A sync message carries the full address and sets the reference. A sync is sent after reset, after any write to the control word, and after an access is lost because the queue was full.

Top module: `dtrace_qual`

## Requirements
- R1: An enabled access of a selected direction is traced only if win_lo <= bus_addr <= win_hi. Both bounds are inclusive. Any address outside the window produces no message.
- R2: When win_lo > win_hi, no access is traced.
- R3: The control word is register 2, written through cfg_sel/cfg_wdata/cfg_we. Bit 0 enables tracing. Bit 1 selects reads and bit 2 selects writes, so mask 01 means reads only, 10 writes only, 11 both and 00 nothing. Register 0 is win_lo and register 1 is win_hi. All three registers reset to 0.
- R4: The first message after reset is a sync message. msg_kind bit 1 is 1, msg_addr is the full address, and msg_nib equals AW/4.
- R5: A non-sync message has msg_kind bit 1 = 0. Its msg_addr is the previous reported address XOR the current address. msg_nib is the 1-based index of the highest nonzero nibble of that XOR, or 0 if the XOR is zero. All payload bits above msg_nib*4 are zero.
- R6: msg_kind bit 0 is 1 for a write and 0 for a read. msg_data carries the bus data of the access.
- R7: Messages leave in the order the accesses were accepted. While msg_valid is high and msg_ready is low, the head message and all its fields stay unchanged.
- R8: A qualifying access that finds the queue holding DEPTH messages is dropped. The next accepted message is a sync.
- R9: A write to the control word forces the next accepted message to be a sync.
- R10: During and directly after reset, msg_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 low bound, 1 high bound, 2 control |
| cfg_wdata | input | AW | Register write data |
| bus_valid | input | 1 | Snooped access is valid this cycle |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | AW | Snooped access address |
| bus_data | input | DW | Snooped access data |
| msg_valid | output | 1 | A message is at the queue head |
| msg_ready | input | 1 | Consumer takes the head message |
| msg_kind | output | 2 | Bit 1 sync, bit 0 write |
| msg_addr | output | AW | Full address (sync) or XOR payload (relative) |
| msg_nib | output | $clog2(AW/4+1) | Number of valid payload nibbles |
| msg_data | output | DW | Access data |

## Verification
The bound checker checks several properties on every cycle. It checks that the head message holds steady under backpressure and that a sync always reports a full-width payload. It checks that a relative payload has no bits above its nibble count, with its top counted nibble nonzero. It also checks that an empty window never lets a message appear. Other behaviour shows only in the bench's scenarios. This covers the exact XOR values and nibble counts, the inclusive window edges, and each direction mask. It also covers the resync after a control write, and the drop of an access into a full queue followed by a forced sync.

// File: rtl/dtrace_qual.sv
module dtrace_qual #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [1:0]                  cfg_sel,
  input  logic [AW-1:0]               cfg_wdata,
  input  logic                        bus_valid,
  input  logic                        bus_write,
  input  logic [AW-1:0]               bus_addr,
  input  logic [DW-1:0]               bus_data,
  output logic                        msg_valid,
  input  logic                        msg_ready,
  output logic [1:0]                  msg_kind,
  output logic [AW-1:0]               msg_addr,
  output logic [$clog2(AW/4+1)-1:0]   msg_nib,
  output logic [DW-1:0]               msg_data
);
  localparam int NIBS = AW / 4;
  localparam int NIBW = $clog2(NIBS + 1);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] win_lo, win_hi, ref_addr;
  logic [2:0]    ctrl;
  logic          resync;

  logic [1:0]      q_kind [DEPTH];
  logic [AW-1:0]   q_addr [DEPTH];
  logic [NIBW-1:0] q_nib  [DEPTH];
  logic [DW-1:0]   q_data [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [PW:0]     cnt;

  wire type_ok = bus_write ? ctrl[2] : ctrl[1];
  wire hit     = bus_valid && ctrl[0] && type_ok &&
                 (bus_addr >= win_lo) && (bus_addr <= win_hi);
  wire full    = (cnt == (PW+1)'(DEPTH));
  wire push    = hit && !full;
  wire pop     = msg_valid && msg_ready;
  wire ctrl_wr = cfg_we && (cfg_sel == 2'd2);

  logic [AW-1:0]   diff;
  logic [NIBW-1:0] nib;
  assign diff = ref_addr ^ bus_addr;

  always_comb begin
    nib = '0;
    for (int i = 0; i < NIBS; i++)
      if (|diff[4*i +: 4]) nib = NIBW'(i + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_lo <= '0;
      win_hi <= '0;
      ctrl   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    win_lo <= cfg_wdata;
        2'd1:    win_hi <= cfg_wdata;
        2'd2:    ctrl   <= cfg_wdata[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resync   <= 1'b1;
      ref_addr <= '0;
    end else begin
      if (push) ref_addr <= bus_addr;
      if (ctrl_wr || (hit && full)) resync <= 1'b1;
      else if (push)                resync <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_kind[wp] <= {resync, bus_write};
      q_addr[wp] <= resync ? bus_addr : diff;
      q_nib[wp]  <= resync ? NIBW'(NIBS) : nib;
      q_data[wp] <= bus_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  assign msg_valid = (cnt != '0);
  assign msg_kind  = q_kind[rp];
  assign msg_addr  = q_addr[rp];
  assign msg_nib   = q_nib[rp];
  assign msg_data  = q_data[rp];
endmodule

module dtrace_qual_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      msg_valid,
  input logic                      msg_ready,
  input logic [1:0]                msg_kind,
  input logic [AW-1:0]             msg_addr,
  input logic [$clog2(AW/4+1)-1:0] msg_nib,
  input logic [DW-1:0]             msg_data,
  input logic [AW-1:0]             win_lo,
  input logic [AW-1:0]             win_hi
);
  localparam int NIBS = AW / 4;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) &&
      $stable(msg_addr) && $stable(msg_nib) && $stable(msg_data));

  assert_sync_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind[1] |-> (int'(msg_nib) == NIBS));

  assert_rel_trunc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_kind[1] |-> ((msg_addr >> (4 * int'(msg_nib))) == '0));

  assert_rel_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_kind[1] && (msg_nib != '0) |->
      ((msg_addr >> (4 * (int'(msg_nib) - 1))) != '0));

  assert_empty_win_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid && (win_lo > win_hi) |=> !msg_valid);

  always @(negedge clk)
    if (!rst_n) assert_idle_R10: assert (!msg_valid);
endmodule

bind dtrace_qual dtrace_qual_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/dtrace_qual_test.sv
module dtrace_qual_test;
  localparam int AW = 32, DW = 32;

  logic          clk = 0, rst_n = 0;
  logic          cfg_we = 0;
  logic [1:0]    cfg_sel = 0;
  logic [AW-1:0] cfg_wdata = 0;
  logic          bus_valid = 0, bus_write = 0;
  logic [AW-1:0] bus_addr = 0;
  logic [DW-1:0] bus_data = 0;
  logic          msg_valid, msg_ready = 0;
  logic [1:0]    msg_kind;
  logic [AW-1:0] msg_addr;
  logic [3:0]    msg_nib;
  logic [DW-1:0] msg_data;

  int checks = 0, errors = 0;

  dtrace_qual #(.AW(AW), .DW(DW), .DEPTH(4)) uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [AW-1:0] val);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = w; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic expect_msg(input string tag, input logic [1:0] k, input logic [AW-1:0] a,
                            input logic [3:0] n, input logic [DW-1:0] d);
    chk({tag, " valid"}, msg_valid, 1);
    chk({tag, " kind"},  msg_kind, k);
    chk({tag, " addr"},  msg_addr, a);
    chk({tag, " nib"},   msg_nib, n);
    chk({tag, " data"},  msg_data, d);
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
  endtask

  task automatic expect_none(input string tag);
    chk({tag, " no message"}, msg_valid, 0);
  endtask

  task automatic t_reset;
    chk("R10 idle after reset", msg_valid, 0);
  endtask

  task automatic t_window;
    cfg(0, 32'h1000); cfg(1, 32'h10FF); cfg(2, 32'h7);
    access(0, 32'h1000, 32'hAAAA0001);
    expect_msg("R4 R1 first sync at low bound", 2'b10, 32'h1000, 4'd8, 32'hAAAA0001);
    access(1, 32'h10FF, 32'hBBBB0002);
    expect_msg("R5 R6 R1 write at high bound", 2'b01, 32'h000000FF, 4'd2, 32'hBBBB0002);
    access(0, 32'h10F0, 32'h3);
    expect_msg("R5 one nibble", 2'b00, 32'h0000000F, 4'd1, 32'h3);
    access(0, 32'h10F0, 32'h4);
    expect_msg("R5 same address", 2'b00, 32'h0, 4'd0, 32'h4);
    access(0, 32'h0FFF, 0);
    expect_none("R1 below window");
    access(1, 32'h1100, 0);
    expect_none("R1 above window");
  endtask

  task automatic t_types;
    cfg(2, 32'h3);
    access(1, 32'h1010, 0);
    expect_none("R3 write masked");
    access(0, 32'h1010, 32'h55);
    expect_msg("R3 R9 read after ctrl write is sync", 2'b10, 32'h1010, 4'd8, 32'h55);
    cfg(2, 32'h5);
    access(0, 32'h1020, 0);
    expect_none("R3 read masked");
    access(1, 32'h1020, 32'h66);
    expect_msg("R3 R9 write sync", 2'b11, 32'h1020, 4'd8, 32'h66);
    access(1, 32'h1024, 32'h77);
    expect_msg("R5 R6 write relative", 2'b01, 32'h4, 4'd1, 32'h77);
    cfg(2, 32'h1);
    access(0, 32'h1030, 0);
    expect_none("R3 mask 00 read");
    access(1, 32'h1030, 0);
    expect_none("R3 mask 00 write");
    cfg(2, 32'h6);
    access(1, 32'h1030, 0);
    expect_none("R3 disabled");
  endtask

  task automatic t_empty;
    cfg(0, 32'h2000); cfg(1, 32'h1000); cfg(2, 32'h7);
    access(0, 32'h1800, 0);
    expect_none("R2 inverted window mid");
    access(1, 32'h2000, 0);
    expect_none("R2 inverted window bound");
  endtask

  task automatic t_overflow;
    cfg(0, 32'h0); cfg(1, 32'hFFFFFFFF); cfg(2, 32'h7);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      bus_valid = 1; bus_write = 1; bus_addr = 32'h100 + i; bus_data = 32'hD0 + i;
    end
    @(negedge clk);
    bus_valid = 0;
    chk("R7 head sync addr", msg_addr, 32'h100);
    repeat (3) @(negedge clk);
    chk("R7 head held", msg_addr, 32'h100);
    chk("R7 head data held", msg_data, 32'hD0);
    expect_msg("R7 order 0", 2'b11, 32'h100, 4'd8, 32'hD0);
    expect_msg("R7 order 1", 2'b01, 32'h1, 4'd1, 32'hD1);
    expect_msg("R7 order 2", 2'b01, 32'h3, 4'd1, 32'hD2);
    expect_msg("R7 order 3", 2'b01, 32'h1, 4'd1, 32'hD3);
    expect_none("R8 dropped access absent");
    access(1, 32'h105, 32'hD5);
    expect_msg("R8 sync after drop", 2'b11, 32'h105, 4'd8, 32'hD5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_window;
    t_types;
    t_empty;
    t_overflow;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule